// File: doc/BRIEF.md
# Debug-Scan Reset Domain Controller

This block is a test-access data register that lets an external debugger or tester hold any of several independent reset domains inside a chip in reset. Each domain has exactly one bit. Bit *i* drives domain *i*. Within one scan the tester captures the active hold mask, shifts a full new mask through the chain least significant bit first, and commits it at Update-DR. A committed 1 pulls that domain's active-low reset low at once and keeps it low while the bit stays set. A committed 0 lets the domain leave reset, and the release is re-timed to that domain's own clock.

The test-access state machine sits outside the block and supplies the instruction register value and the Capture-DR, Shift-DR and Update-DR strobes. The block does not decide what each domain contains. The register responds only when the 5-bit instruction equals 0x0C.

An access sequencer tracks each scan through three states:

- ACC_IDLE moves to ACC_CAPTURED on a selected capture.
- ACC_CAPTURED moves to ACC_SHIFTING on a selected shift.
- ACC_CAPTURED and ACC_SHIFTING move to ACC_CAPTURED on a repeated capture.
- ACC_CAPTURED and ACC_SHIFTING return to ACC_IDLE on a selected update, which commits the mask.
- ACC_CAPTURED and ACC_SHIFTING also return to ACC_IDLE when the instruction changes away from 0x0C.
- A test-logic reset forces ACC_IDLE from any state.

Top module: `rstdom_ctrl`

## Requirements
- R1: The register responds only while `ir_value` equals 5'h0C. Under any other instruction, the capture, shift and update strobes leave the mask and the reset outputs unchanged.
- R2: While committed mask bit *i* is 1, `dom_rst_n[i]` stays 0 for as long as the bit remains set.
- R3: When mask bit *i* is committed to 0, `dom_rst_n[i]` stays 0 until the SYNC_STAGES-th rising edge of `dom_clk[i]` after the update, and rises at that edge. The default SYNC_STAGES is 2.
- R4: Reset assertion is asynchronous. `dom_rst_n[i]` goes low after the update edge that sets bit *i*, even when `dom_clk[i]` is stopped.
- R5: Shifting is LSB first. On each shift, `tdi` enters at bit NUM_DOMAINS-1 and `tdo` always shows bit 0. The first bit shifted in becomes mask bit 0.
- R6: Capture-DR loads the committed mask into the chain, so the bits read on `tdo` during the following shifts are mask bit 0 first.
- R7: The mask and the reset outputs change only at a committing Update-DR. Capture and shift cycles, including a partial shift, leave them unchanged.
- R8: An Update-DR that arrives in ACC_IDLE (with no capture of this register since the last commit or instruction change) is ignored.
- R9: Either `tap_reset` high at a `tck` edge, or `trst_n` low at any time, clears the chain, the mask and the sequencer. After the sync delay this releases every domain.
- R10: The sequencer follows the states ACC_IDLE, ACC_CAPTURED and ACC_SHIFTING with the transitions given above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tap_reset | input | 1 | Synchronous strobe, high while the controller is in Test-Logic-Reset |
| ir_value | input | 5 | Current instruction register contents |
| capture_dr | input | 1 | Capture-DR strobe |
| shift_dr | input | 1 | Shift-DR strobe |
| update_dr | input | 1 | Update-DR strobe |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, chain bit 0 |
| dom_clk | input | NUM_DOMAINS | Clock of each reset domain |
| dom_rst_n | output | NUM_DOMAINS | Active-low reset of each domain |

## Verification
The bench builds the block with NUM_DOMAINS = 3 and SYNC_STAGES = 2.

An odd width with unequal bit patterns such as 001 and 110 exposes any reversal of the shift order. Three domain clocks with unrelated periods exercise the per-domain release independently.

The domain clocks can be frozen. This makes the asynchronous assertion and the exact two-edge release delay observable at the ports.

// File: rtl/rstdom_pkg.sv
package rstdom_pkg;
    localparam int IR_W = 5;
    localparam logic [IR_W-1:0] OPC_RSTDOM = 5'h0C;

    typedef enum logic [1:0] {
        ACC_IDLE     = 2'd0,
        ACC_CAPTURED = 2'd1,
        ACC_SHIFTING = 2'd2
    } acc_state_e;
endpackage

// File: rtl/rstdom_decode.sv
module rstdom_decode
    import rstdom_pkg::*;
(
    input  logic [IR_W-1:0] ir_value,
    output logic            sel
);
    // The chain is selected by a single opcode; every other value deselects it.
    always_comb begin
        sel = (ir_value == OPC_RSTDOM);
    end
endmodule

// File: rtl/rstdom_chain.sv
module rstdom_chain
    import rstdom_pkg::*;
#(
    parameter int NUM_DOMAINS = 4
) (
    input  logic                   tck,
    input  logic                   trst_n,
    input  logic                   tap_reset,
    input  logic                   sel,
    input  logic                   capture_dr,
    input  logic                   shift_dr,
    input  logic                   update_dr,
    input  logic                   tdi,
    output logic                   tdo,
    output logic [NUM_DOMAINS-1:0] hold
);
    localparam int MSB = NUM_DOMAINS - 1;

    acc_state_e             state_q, state_d;
    logic                   cap_en, shift_en, commit_en;
    logic [NUM_DOMAINS-1:0] shreg_q;
    logic [NUM_DOMAINS-1:0] hold_q;

    // State register
    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            state_q <= ACC_IDLE;
        end else if (tap_reset) begin
            state_q <= ACC_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ACC_IDLE: begin
                if (sel && capture_dr) state_d = ACC_CAPTURED;
            end
            ACC_CAPTURED, ACC_SHIFTING: begin
                if (!sel || update_dr) state_d = ACC_IDLE;
                else if (capture_dr)   state_d = ACC_CAPTURED;
                else if (shift_dr)     state_d = ACC_SHIFTING;
            end
            default: state_d = ACC_IDLE;
        endcase
    end

    // Output decode: which datapath action this cycle performs
    always_comb begin
        cap_en    = sel && capture_dr;
        shift_en  = 1'b0;
        commit_en = 1'b0;
        unique case (state_q)
            ACC_IDLE: begin
                shift_en  = 1'b0;
                commit_en = 1'b0;
            end
            ACC_CAPTURED, ACC_SHIFTING: begin
                shift_en  = sel && shift_dr && !capture_dr;
                commit_en = sel && update_dr;
            end
            default: begin
                shift_en  = 1'b0;
                commit_en = 1'b0;
            end
        endcase
    end

    // Shift chain and committed hold mask
    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            shreg_q <= '0;
            hold_q  <= '0;
        end else if (tap_reset) begin
            shreg_q <= '0;
            hold_q  <= '0;
        end else begin
            if (cap_en) begin
                shreg_q <= hold_q;
            end else if (shift_en) begin
                shreg_q <= {tdi, shreg_q[MSB:1]};
            end
            if (commit_en) begin
                hold_q <= shreg_q;
            end
        end
    end

    always_comb begin
        tdo  = shreg_q[0];
        hold = hold_q;
    end

    AST_SHIFT_ENTERS_MSB: assert property (@(posedge tck) disable iff (!trst_n)
        (state_q != ACC_IDLE && sel && shift_dr && !capture_dr && !tap_reset)
            |=> (shreg_q[MSB] == $past(tdi))) else $error("shift order"); // R5
    AST_CAPTURE_LOADS_MASK: assert property (@(posedge tck) disable iff (!trst_n)
        (sel && capture_dr && !tap_reset) |=> (shreg_q == $past(hold_q))) else $error("capture"); // R6
    AST_MASK_ONLY_ON_UPDATE: assert property (@(posedge tck) disable iff (!trst_n)
        (!update_dr && !tap_reset) |=> $stable(hold_q)) else $error("mask moved"); // R7
    AST_IDLE_NO_COMMIT: assert property (@(posedge tck) disable iff (!trst_n)
        (state_q == ACC_IDLE && !tap_reset) |=> $stable(hold_q)) else $error("idle commit"); // R8
    AST_TLR_CLEARS: assert property (@(posedge tck) disable iff (!trst_n)
        tap_reset |=> (hold_q == '0 && state_q == ACC_IDLE)) else $error("tlr"); // R9
endmodule

// File: rtl/rstdom_sync.sv
module rstdom_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_i,
    input  logic hold_i,
    input  logic tap_rst_n,
    output logic rst_n_o
);
    localparam int LAST = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] pipe_q;

    // Assert at once through the async clear; release walks a 1 through the chain.
    always_ff @(posedge clk_i or posedge hold_i) begin
        if (hold_i) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= {pipe_q[LAST-1:0], 1'b1};
        end
    end

    always_comb begin
        rst_n_o = pipe_q[LAST];
    end

    AST_HELD_DOMAIN_LOW: assert property (@(posedge clk_i) disable iff (!tap_rst_n)
        hold_i |-> !rst_n_o) else $error("domain not held"); // R2
endmodule

// File: rtl/rstdom_ctrl.sv
module rstdom_ctrl
    import rstdom_pkg::*;
#(
    parameter int NUM_DOMAINS = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                   tck,
    input  logic                   trst_n,
    input  logic                   tap_reset,
    input  logic [4:0]             ir_value,
    input  logic                   capture_dr,
    input  logic                   shift_dr,
    input  logic                   update_dr,
    input  logic                   tdi,
    output logic                   tdo,
    input  logic [NUM_DOMAINS-1:0] dom_clk,
    output logic [NUM_DOMAINS-1:0] dom_rst_n
);
    logic                   sel;
    logic [NUM_DOMAINS-1:0] hold;

    rstdom_decode u_decode (
        .ir_value (ir_value),
        .sel      (sel)
    );

    rstdom_chain #(.NUM_DOMAINS(NUM_DOMAINS)) u_chain (
        .tck        (tck),
        .trst_n     (trst_n),
        .tap_reset  (tap_reset),
        .sel        (sel),
        .capture_dr (capture_dr),
        .shift_dr   (shift_dr),
        .update_dr  (update_dr),
        .tdi        (tdi),
        .tdo        (tdo),
        .hold       (hold)
    );

    for (genvar d = 0; d < NUM_DOMAINS; d++) begin : g_dom
        rstdom_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
            .clk_i     (dom_clk[d]),
            .hold_i    (hold[d]),
            .tap_rst_n (trst_n),
            .rst_n_o   (dom_rst_n[d])
        );
    end
endmodule

// File: tb/rstdom_ctrl_test.sv
module rstdom_ctrl_test;
    localparam int ND = 3;
    localparam logic [4:0] OPC = 5'h0C;

    logic tck = 1'b0;
    always #5 tck = ~tck;

    logic trst_n = 1'b0, tap_reset = 1'b0, cap = 1'b0, sh = 1'b0, upd = 1'b0, tdi = 1'b0;
    logic [4:0] ir = 5'h00;
    logic tdo;
    logic [ND-1:0] drn;
    logic dclk0 = 1'b0, dclk1 = 1'b0, dclk2 = 1'b0, den = 1'b1;
    always #7  if (den) dclk0 = ~dclk0;
    always #11 if (den) dclk1 = ~dclk1;
    always #3  if (den) dclk2 = ~dclk2;

    rstdom_ctrl #(.NUM_DOMAINS(ND), .SYNC_STAGES(2)) uut (
        .tck(tck), .trst_n(trst_n), .tap_reset(tap_reset), .ir_value(ir),
        .capture_dr(cap), .shift_dr(sh), .update_dr(upd), .tdi(tdi), .tdo(tdo),
        .dom_clk({dclk2, dclk1, dclk0}), .dom_rst_n(drn)
    );

    int checks = 0, errors = 0;
    bit live = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Behavioural reference: queue of chain bits (front = tdo), committed mask, armed flag
    bit mq[$];
    logic [ND-1:0] mmask;
    bit marmed;

    task automatic model_clear();
        mq.delete();
        for (int i = 0; i < ND; i++) mq.push_back(1'b0);
        mmask = '0;
        marmed = 0;
    endtask

    initial model_clear();

    always @(posedge tck or negedge trst_n) begin
        if (!trst_n || tap_reset) begin
            model_clear();
        end else if (ir == OPC) begin
            if (cap) begin
                mq.delete();
                for (int i = 0; i < ND; i++) mq.push_back(mmask[i]);
                marmed = 1;
            end else if (sh && marmed) begin
                void'(mq.pop_front());
                mq.push_back(tdi);
            end else if (upd && marmed) begin
                for (int i = 0; i < ND; i++) mmask[i] = mq[i];
                marmed = 0;
            end
        end else begin
            marmed = 0;
        end
    end

    // Every-clock comparison against the model
    always @(negedge tck) begin
        if (live) begin
            chk(tdo === mq[0], "R5 tdo vs model", tdo, mq[0]);
            for (int i = 0; i < ND; i++)
                if (mmask[i]) chk(drn[i] === 1'b0, "R2 held domain low", drn[i], 0);
        end
    end

    task automatic scan_ir(input logic [4:0] irv, input logic [ND-1:0] wr, output logic [ND-1:0] rd);
        @(negedge tck); ir = irv; cap = 1'b1;
        @(negedge tck); cap = 1'b0;
        for (int k = 0; k < ND; k++) begin
            rd[k] = tdo; sh = 1'b1; tdi = wr[k];
            @(negedge tck);
        end
        sh = 1'b0; upd = 1'b1;
        @(negedge tck); upd = 1'b0;
    endtask

    task automatic scan(input logic [ND-1:0] wr, output logic [ND-1:0] rd);
        scan_ir(OPC, wr, rd);
    endtask

    logic [ND-1:0] rd;

    initial begin
        // Reset
        repeat (3) @(negedge tck);
        trst_n = 1'b1; live = 1;
        repeat (10) @(negedge tck);
        chk(drn === 3'b111, "R9 released after reset", drn, 3'b111);
        scan(3'b000, rd);
        chk(rd === 3'b000, "R6 reset readback", rd, 3'b000);

        // Hold domain 0 only
        scan(3'b001, rd);
        chk(drn === 3'b110, "R2 bit0 holds domain0", drn, 3'b110);
        repeat (50) @(negedge tck);
        chk(drn === 3'b110, "R2 still held", drn, 3'b110);

        // LSB-first readback
        scan(3'b101, rd);
        chk(rd === 3'b001, "R5 R6 readback order", rd, 3'b001);
        chk(drn === 3'b010, "R2 mask 101", drn, 3'b010);

        // Partial shift has no effect on outputs
        @(negedge tck); ir = OPC; cap = 1'b1;
        @(negedge tck); cap = 1'b0; sh = 1'b1; tdi = 1'b0;
        @(negedge tck); tdi = 1'b1;
        @(negedge tck); sh = 1'b0;
        repeat (4) @(negedge tck);
        chk(drn === 3'b010, "R7 partial shift ignored", drn, 3'b010);
        sh = 1'b1; tdi = 1'b0;
        @(negedge tck); sh = 1'b0; upd = 1'b1;
        @(negedge tck); upd = 1'b0;
        chk(drn[1] === 1'b0, "R7 commit at update", drn[1], 0);
        repeat (10) @(negedge tck);
        chk(drn === 3'b101, "R10 mask 010 after full scan", drn, 3'b101);

        // Other instructions ignored
        scan_ir(5'h17, 3'b111, rd);
        scan_ir(5'h0D, 3'b111, rd);
        repeat (3) @(negedge tck);
        chk(drn === 3'b101, "R1 other opcode ignored", drn, 3'b101);
        scan(3'b010, rd);
        chk(rd === 3'b010, "R1 mask unchanged readback", rd, 3'b010);

        // Update without capture in the same access is ignored
        @(negedge tck); ir = OPC; cap = 1'b1;
        @(negedge tck); cap = 1'b0;
        for (int k = 0; k < ND; k++) begin sh = 1'b1; tdi = 1'b1; @(negedge tck); end
        sh = 1'b0; ir = 5'h17;
        @(negedge tck); ir = OPC;
        @(negedge tck); upd = 1'b1;
        @(negedge tck); upd = 1'b0;
        repeat (3) @(negedge tck);
        chk(drn === 3'b101, "R8 idle update ignored", drn, 3'b101);
        scan(3'b010, rd);
        chk(rd === 3'b010, "R8 mask unchanged readback", rd, 3'b010);

        // Asynchronous assertion with domain clocks stopped
        den = 1'b0;
        scan(3'b111, rd);
        chk(drn === 3'b000, "R4 async assert, clocks stopped", drn, 3'b000);

        // Release of domain 0 waits for two of its own clock edges
        scan(3'b110, rd);
        repeat (5) @(negedge tck);
        chk(drn[0] === 1'b0, "R3 no release without domain clock", drn[0], 0);
        den = 1'b1;
        @(posedge dclk0); #1;
        chk(drn[0] === 1'b0, "R3 still low after first edge", drn[0], 0);
        @(posedge dclk0); #1;
        chk(drn[0] === 1'b1, "R3 released at second edge", drn[0], 1);

        // Test-logic-reset strobe clears everything
        @(negedge tck); tap_reset = 1'b1;
        @(negedge tck); tap_reset = 1'b0;
        repeat (10) @(negedge tck);
        chk(drn === 3'b111, "R9 strobe releases all", drn, 3'b111);
        scan(3'b101, rd);
        chk(rd === 3'b000, "R9 strobe cleared mask", rd, 3'b000);

        // Asynchronous test reset mid-cycle
        @(negedge tck); #2 trst_n = 1'b0;
        repeat (10) @(negedge tck);
        chk(drn === 3'b111, "R9 trst releases all", drn, 3'b111);
        trst_n = 1'b1;
        scan(3'b000, rd);
        chk(rd === 3'b000, "R9 trst cleared mask", rd, 3'b000);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #2000000;
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule